// File: doc/BRIEF.md
# Time-Multiplexed State-Variable Filter

This block is a two-integrator state-variable filter that serves several sound chips (two by default) with one shared signed multiply-add unit. A free-running slot counter splits time into frames of `FRAME_LEN` cycles. Chip k runs a nine-cycle schedule that starts at slot 5k. During that schedule it sums three voice samples and an external sample into either a direct-path sum or a filter-input sum. It then advances its low-pass, band-pass and high-pass state through the shared unit, mixes the selected filter outputs, and scales the result by a 4-bit volume.

All voice samples arrive on one shared `sample_i` bus. The slot shown on `slot_o` tells the driver which chip and input is consumed at the next clock edge. Each chip's routing, mode, volume, frequency coefficient and inverse resonance come in on per-chip port slices, and they must stay stable while that chip's schedule runs. The cutoff coefficient and the resonance coefficient are supplied already computed, in signed fixed point with `COEF_FRAC` fraction bits.

Top module: `svf_tdm_filter`

## Requirements
- R1: After reset `slot_o` is 0, `audio_o` and `valid_o` are all zero. `slot_o` then advances by one each cycle and wraps from `FRAME_LEN-1` to 0.
- R2: Chip k clears both input sums when `slot_o` is 5k. It consumes `sample_i` as voice 1, 2, 3 and then the external input when `slot_o` is 5k+1, 5k+2, 5k+3 and 5k+4. Route bit j of the chip's 4-bit route field (bits 0..2 are the voices, bit 3 is the external input) sends input j to the filter-input sum when 1 and to the direct-path sum when 0.
- R3: Every sum and every state value is 16-bit signed two's complement. On overflow it saturates to 32767 or -32768, and each addition saturates in turn, in the order of the inputs.
- R4: Each frame the low-pass state becomes lp + m1, saturated. Here m1 = -floor(fc*bp / 2^14), using the band-pass state from the previous frame.
- R5: Each frame the band-pass state becomes bp + m2, saturated. Here m2 = -floor(fc*hp / 2^14), using the high-pass state from the previous frame.
- R6: Each frame the high-pass state becomes sat(sat(-(lp_new + vi)) + floor(inv_q*bp_old / 2^14)). Here vi is the filter-input sum of this frame.
- R7: Mode bit 0, 1 and 2 of the chip's 3-bit mode field add the new low-pass, band-pass and high-pass value, in that order, into a filter-output sum that starts at zero. A cleared bit leaves that value out.
- R8: The chip's audio is floor(vol * 2^10 * sat(vd + vf) / 2^14), saturated. It appears on its `audio_o` slice, together with a one-cycle `valid_o[k]` pulse, when `slot_o` is 5k+8, and the slice holds that value until the next pulse.
- R9: The chips keep separate state and settings. Their schedules are offset by 5 cycles, so no two chips use the shared multiply-add unit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | W | Shared voice / external sample, signed |
| route_i | input | NUM_CHIPS*4 | Per-chip routing bits, 1 = filter input |
| mode_i | input | NUM_CHIPS*3 | Per-chip low/band/high-pass mix enables |
| vol_i | input | NUM_CHIPS*VOL_W | Per-chip volume, unsigned |
| fc_i | input | NUM_CHIPS*CW | Per-chip frequency coefficient, signed Q(COEF_FRAC) |
| inv_q_i | input | NUM_CHIPS*CW | Per-chip inverse resonance, signed Q(COEF_FRAC) |
| slot_o | output | $clog2(FRAME_LEN) | Slot consumed at the next clock edge |
| audio_o | output | NUM_CHIPS*W | Per-chip audio sample, signed |
| valid_o | output | NUM_CHIPS | Per-chip one-cycle audio strobe |

## Verification
The bench builds the block with its defaults: two chips, a 20-cycle frame, 16-bit samples and state, 16-bit coefficients with 14 fraction bits, and a 4-bit volume. With these values, four full-scale samples are enough to drive the direct sum into saturation, which makes the saturation limits reachable. The second chip's five-cycle offset puts its use of the multiply-add unit directly after the first chip's volume step, so the handoff on the shared unit is exercised. Coefficients reach up to almost 2.0, so the resonance term can also drive the integrator state into its limits.

// File: rtl/svf_pkg.sv
package svf_pkg;
  localparam int CHIP_STRIDE = 5;  // schedule offset between chips
  localparam int LANE_CYCLES = 9;  // cycles of one chip schedule
  localparam int NUM_INPUTS  = 4;  // three voices + external
  localparam int NUM_TAPS    = 3;  // low, band, high

  // phase indices within a chip schedule
  localparam int PH_CLEAR = 0;
  localparam int PH_LPMUL = 3;
  localparam int PH_LPUPD = 4;
  localparam int PH_BPUPD = 5;
  localparam int PH_HPUPD = 6;
  localparam int PH_VOL   = 7;
endpackage

// File: rtl/svf_sched.sv
module svf_sched #(
  parameter int NUM_CHIPS = 2,
  parameter int FRAME_LEN = 20,
  localparam int SLOT_W = $clog2(FRAME_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic [SLOT_W-1:0] slot_o,
  output logic [NUM_CHIPS-1:0][svf_pkg::LANE_CYCLES-1:0] phase_o
);
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              slot_q <= '0;
    else if (slot_q == SLOT_W'(FRAME_LEN-1))  slot_q <= '0;
    else                                      slot_q <= slot_q + 1'b1;
  end

  assign slot_o = slot_q;

  for (genvar k = 0; k < NUM_CHIPS; k++) begin : g_chip
    for (genvar p = 0; p < svf_pkg::LANE_CYCLES; p++) begin : g_ph
      assign phase_o[k][p] = (slot_q == SLOT_W'(k*svf_pkg::CHIP_STRIDE + p));
    end
  end
endmodule

// File: rtl/svf_mac.sv
module svf_mac #(
  parameter int W    = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  localparam int PW  = CW + W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [CW-1:0] a_i,
  input  logic signed [W-1:0]  b_i,
  input  logic signed [W-1:0]  c_i,
  input  logic                 neg_i,
  output logic signed [W-1:0]  y_d_o,
  output logic signed [W-1:0]  y_q_o
);
  logic signed [PW-1:0] prod, shf;
  logic signed [PW:0]   term;
  logic signed [PW+1:0] sum;
  logic                 ovf;

  always_comb begin
    prod = a_i * b_i;
    shf  = prod >>> FRAC;
    term = neg_i ? -$signed({shf[PW-1], shf}) : $signed({shf[PW-1], shf});
    sum  = $signed({term[PW], term}) + $signed({{(PW+2-W){c_i[W-1]}}, c_i});
    ovf  = !((&sum[PW+1:W-1]) || !(|sum[PW+1:W-1]));
    if (ovf) y_d_o = sum[PW+1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else     y_d_o = sum[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_q_o <= '0;
    else         y_q_o <= y_d_o;
  end
endmodule

// File: rtl/svf_lane.sv
module svf_lane #(
  parameter int W     = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 14,
  parameter int VOL_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [svf_pkg::LANE_CYCLES-1:0] phase_i,
  input  logic signed [W-1:0]  sample_i,
  input  logic [svf_pkg::NUM_INPUTS-1:0] route_i,
  input  logic [svf_pkg::NUM_TAPS-1:0]   mode_i,
  input  logic [VOL_W-1:0]     vol_i,
  input  logic signed [CW-1:0] fc_i,
  input  logic signed [CW-1:0] inv_q_i,
  input  logic signed [W-1:0]  mac_q_i,
  input  logic signed [W-1:0]  mac_d_i,
  output logic                 req_o,
  output logic signed [CW-1:0] a_o,
  output logic signed [W-1:0]  b_o,
  output logic signed [W-1:0]  c_o,
  output logic                 neg_o,
  output logic signed [W-1:0]  audio_o,
  output logic                 valid_o
);
  import svf_pkg::*;

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] add_sat(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s = {x[W-1], x} + {y[W-1], y};
    if (s[W] != s[W-1]) return s[W] ? MINV : MAXV;
    return s[W-1:0];
  endfunction

  logic signed [W-1:0] vd_q, vi_q, vf_q, lp_q, bp_q, hp_q;
  logic signed [W-1:0] lp_n, bp_n, neg_sum, mix;
  logic [W+1:0]        ns_raw;
  logic [CW-1:0]       vol_coef;
  logic                acc_en, to_filt;

  always_comb begin
    lp_n     = add_sat(lp_q, mac_q_i);
    bp_n     = add_sat(bp_q, mac_q_i);
    mix      = add_sat(vd_q, vf_q);
    ns_raw   = -({{2{lp_q[W-1]}}, lp_q} + {{2{vi_q[W-1]}}, vi_q});
    if ((&ns_raw[W+1:W-1]) || !(|ns_raw[W+1:W-1])) neg_sum = ns_raw[W-1:0];
    else neg_sum = ns_raw[W+1] ? MINV : MAXV;
    vol_coef = {{(CW-VOL_W){1'b0}}, vol_i} << (FRAC - VOL_W);
    acc_en   = |phase_i[NUM_INPUTS:1];
    to_filt  = |(phase_i[NUM_INPUTS:1] & route_i);
  end

  // shared-unit request for this lane's arithmetic phases
  always_comb begin
    req_o = 1'b0; a_o = '0; b_o = '0; c_o = '0; neg_o = 1'b0;
    if (phase_i[PH_LPMUL]) begin
      req_o = 1'b1; a_o = fc_i; b_o = bp_q; neg_o = 1'b1;
    end else if (phase_i[PH_LPUPD]) begin
      req_o = 1'b1; a_o = fc_i; b_o = hp_q; neg_o = 1'b1;
    end else if (phase_i[PH_BPUPD]) begin
      req_o = 1'b1; a_o = inv_q_i; b_o = bp_q; c_o = neg_sum;
    end else if (phase_i[PH_VOL]) begin
      req_o = 1'b1; a_o = vol_coef; b_o = mix;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vd_q <= '0; vi_q <= '0;
    end else if (phase_i[PH_CLEAR]) begin
      vd_q <= '0; vi_q <= '0;
    end else if (acc_en) begin
      if (to_filt) vi_q <= add_sat(vi_q, sample_i);
      else         vd_q <= add_sat(vd_q, sample_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vf_q <= '0; lp_q <= '0; bp_q <= '0; hp_q <= '0; audio_o <= '0;
    end else if (phase_i[PH_LPMUL]) begin
      vf_q <= '0;
    end else if (phase_i[PH_LPUPD]) begin
      lp_q <= lp_n;
      if (mode_i[0]) vf_q <= add_sat(vf_q, lp_n);
    end else if (phase_i[PH_BPUPD]) begin
      bp_q <= bp_n;
      if (mode_i[1]) vf_q <= add_sat(vf_q, bp_n);
    end else if (phase_i[PH_HPUPD]) begin
      hp_q <= mac_q_i;
      if (mode_i[2]) vf_q <= add_sat(vf_q, mac_q_i);
    end else if (phase_i[PH_VOL]) begin
      audio_o <= mac_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= phase_i[PH_VOL];
  end
endmodule

// File: rtl/svf_tdm_filter.sv
module svf_tdm_filter #(
  parameter int NUM_CHIPS = 2,
  parameter int FRAME_LEN = 20,
  parameter int W         = 16,
  parameter int CW        = 16,
  parameter int COEF_FRAC = 14,
  parameter int VOL_W     = 4,
  localparam int SLOT_W   = $clog2(FRAME_LEN)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [W-1:0]      sample_i,
  input  logic [NUM_CHIPS*4-1:0]   route_i,
  input  logic [NUM_CHIPS*3-1:0]   mode_i,
  input  logic [NUM_CHIPS*VOL_W-1:0] vol_i,
  input  logic [NUM_CHIPS*CW-1:0]  fc_i,
  input  logic [NUM_CHIPS*CW-1:0]  inv_q_i,
  output logic [SLOT_W-1:0]        slot_o,
  output logic [NUM_CHIPS*W-1:0]   audio_o,
  output logic [NUM_CHIPS-1:0]     valid_o
);
  import svf_pkg::*;

  initial begin
    if (FRAME_LEN < CHIP_STRIDE*(NUM_CHIPS-1) + LANE_CYCLES)
      $error("FRAME_LEN too short for NUM_CHIPS schedules");
    if (COEF_FRAC < VOL_W || COEF_FRAC >= CW)
      $error("COEF_FRAC must lie in [VOL_W, CW-1]");
  end

  logic [NUM_CHIPS-1:0][LANE_CYCLES-1:0] phase;
  logic [NUM_CHIPS-1:0]   lane_req, lane_neg;
  logic signed [CW-1:0]   lane_a [NUM_CHIPS];
  logic signed [W-1:0]    lane_b [NUM_CHIPS];
  logic signed [W-1:0]    lane_c [NUM_CHIPS];
  logic signed [CW-1:0]   mac_a;
  logic signed [W-1:0]    mac_b, mac_c, mac_d, mac_q;
  logic                   mac_neg;

  svf_sched #(.NUM_CHIPS(NUM_CHIPS), .FRAME_LEN(FRAME_LEN)) u_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_o(slot_o), .phase_o(phase)
  );

  // lanes zero their request outside their phases, so OR merges them
  always_comb begin
    mac_a = '0; mac_b = '0; mac_c = '0; mac_neg = 1'b0;
    for (int k = 0; k < NUM_CHIPS; k++) begin
      mac_a   = mac_a | lane_a[k];
      mac_b   = mac_b | lane_b[k];
      mac_c   = mac_c | lane_c[k];
      mac_neg = mac_neg | lane_neg[k];
    end
  end

  svf_mac #(.W(W), .CW(CW), .FRAC(COEF_FRAC)) u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(mac_a), .b_i(mac_b), .c_i(mac_c),
    .neg_i(mac_neg), .y_d_o(mac_d), .y_q_o(mac_q)
  );

  for (genvar k = 0; k < NUM_CHIPS; k++) begin : g_lane
    svf_lane #(.W(W), .CW(CW), .FRAC(COEF_FRAC), .VOL_W(VOL_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .phase_i (phase[k]),
      .sample_i(sample_i),
      .route_i (route_i[k*4 +: 4]),
      .mode_i  (mode_i[k*3 +: 3]),
      .vol_i   (vol_i[k*VOL_W +: VOL_W]),
      .fc_i    (fc_i[k*CW +: CW]),
      .inv_q_i (inv_q_i[k*CW +: CW]),
      .mac_q_i (mac_q),
      .mac_d_i (mac_d),
      .req_o   (lane_req[k]),
      .a_o     (lane_a[k]),
      .b_o     (lane_b[k]),
      .c_o     (lane_c[k]),
      .neg_o   (lane_neg[k]),
      .audio_o (audio_o[k*W +: W]),
      .valid_o (valid_o[k])
    );
  end
endmodule

// File: rtl/svf_tdm_filter_chk.sv
module svf_tdm_filter_chk #(
  parameter int NUM_CHIPS = 2,
  parameter int FRAME_LEN = 20,
  parameter int W         = 16,
  localparam int SLOT_W   = $clog2(FRAME_LEN)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [SLOT_W-1:0]      slot_i,
  input logic [NUM_CHIPS-1:0]   valid_i,
  input logic [NUM_CHIPS*W-1:0] audio_i,
  input logic [NUM_CHIPS-1:0]   req_i
);
  AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i == SLOT_W'(FRAME_LEN-1) |=> slot_i == '0); // R1
  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i != SLOT_W'(FRAME_LEN-1) |=> slot_i == $past(slot_i) + 1'b1); // R1
  AST_ONE_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_i)); // R9
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(valid_i)); // R9

  for (genvar k = 0; k < NUM_CHIPS; k++) begin : g_chk
    AST_STROBE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i[k] |-> slot_i == SLOT_W'(k*svf_pkg::CHIP_STRIDE + 8)); // R8
    AST_AUDIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(audio_i[k*W +: W]) |-> valid_i[k]); // R8
  end
endmodule

bind svf_tdm_filter svf_tdm_filter_chk #(
  .NUM_CHIPS(NUM_CHIPS), .FRAME_LEN(FRAME_LEN), .W(W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .slot_i(slot_o), .valid_i(valid_o),
  .audio_i(audio_o), .req_i(lane_req)
);

// File: tb/svf_tdm_filter_test.sv
module svf_tdm_filter_test;
  localparam int NC = 2;
  localparam int FL = 20;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic signed [15:0] sample_i = '0;
  logic [NC*4-1:0]   route_i;
  logic [NC*3-1:0]   mode_i;
  logic [NC*4-1:0]   vol_i;
  logic [NC*16-1:0]  fc_i, inv_q_i;
  logic [4:0]        slot_o;
  logic [NC*16-1:0]  audio_o;
  logic [NC-1:0]     valid_o;

  logic [3:0]  rt [NC];
  logic [2:0]  md [NC];
  logic [3:0]  vl [NC];
  int          fc [NC];
  int          iq [NC];

  assign route_i = {rt[1], rt[0]};
  assign mode_i  = {md[1], md[0]};
  assign vol_i   = {vl[1], vl[0]};
  assign fc_i    = {fc[1][15:0], fc[0][15:0]};
  assign inv_q_i = {iq[1][15:0], iq[0][15:0]};

  svf_tdm_filter uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .route_i(route_i),
    .mode_i(mode_i), .vol_i(vol_i), .fc_i(fc_i), .inv_q_i(inv_q_i),
    .slot_o(slot_o), .audio_o(audio_o), .valid_o(valid_o)
  );

  always #2ns clk_i = ~clk_i;

  int checks = 0, fails = 0;
  int exp_slot = 0;
  int smode = 0;
  string cur_tag = "R1";
  int mlp [NC], mbp [NC], mhp [NC];
  int smp [NC][4];
  int exp_audio [NC];
  bit done = 1'b0;

  function automatic int clamp(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int mac(int a, int b, int c, bit neg);
    longint p, sh;
    p  = longint'(a) * longint'(b);
    sh = p >>> 14;
    if (neg) sh = -sh;
    return clamp(sh + longint'(c));
  endfunction

  function automatic int model_chip(int k);
    int vd = 0, vi = 0, vf = 0, lpn, bpn, hpn, ct;
    for (int j = 0; j < 4; j++)
      if (rt[k][j]) vi = clamp(vi + smp[k][j]);
      else          vd = clamp(vd + smp[k][j]);
    lpn = clamp(mlp[k] + mac(fc[k], mbp[k], 0, 1));
    bpn = clamp(mbp[k] + mac(fc[k], mhp[k], 0, 1));
    ct  = clamp(-(longint'(lpn) + vi));
    hpn = mac(iq[k], mbp[k], ct, 0);
    if (md[k][0]) vf = clamp(vf + lpn);
    if (md[k][1]) vf = clamp(vf + bpn);
    if (md[k][2]) vf = clamp(vf + hpn);
    mlp[k] = lpn; mbp[k] = bpn; mhp[k] = hpn;
    return mac(int'(vl[k]) << 10, clamp(vd + vf), 0, 0);
  endfunction

  task automatic chk(bit ok, string tag, string what, int got, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int gen_sample();
    case (smode)
      1:       return 32767;
      2:       return -32768;
      3:       return int'($urandom_range(2046)) - 1023;
      default: return int'($signed(16'($urandom)));
    endcase
  endfunction

  task automatic step();
    int s = int'(slot_o);
    int v;
    logic [NC-1:0] vmask;
    chk(s == exp_slot, "R1", "slot", s, exp_slot);
    for (int k = 0; k < NC; k++) vmask[k] = (s == 5*k + 8);
    chk(valid_o == vmask, "R8", "valid", int'(valid_o), int'(vmask));
    for (int k = 0; k < NC; k++) begin
      if (s == 5*k + 8) begin
        exp_audio[k] = model_chip(k);
        chk($signed(audio_o[k*16 +: 16]) == exp_audio[k], cur_tag, $sformatf("audio chip %0d", k),
            int'($signed(audio_o[k*16 +: 16])), exp_audio[k]);
      end else if (s == 0) begin
        chk($signed(audio_o[k*16 +: 16]) == exp_audio[k], "R8", $sformatf("held audio chip %0d", k),
            int'($signed(audio_o[k*16 +: 16])), exp_audio[k]);
      end
    end
    v = gen_sample();
    sample_i = 16'(v);
    for (int k = 0; k < NC; k++)
      if (s >= 5*k + 1 && s <= 5*k + 4) smp[k][s - 5*k - 1] = v;
    exp_slot = (exp_slot + 1) % FL;
    @(negedge clk_i);
  endtask

  task automatic frames(int n);
    repeat (n * FL) step();
  endtask

  task automatic set_cfg(int k, logic [3:0] r, logic [2:0] m, logic [3:0] v, int f, int q);
    rt[k] = r; md[k] = m; vl[k] = v; fc[k] = f; iq[k] = q;
  endtask

  task automatic rand_cfg(int k);
    set_cfg(k, 4'($urandom), 3'($urandom), 4'($urandom), int'($urandom_range(16383)),
            int'($urandom_range(32767)));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < NC; k++) begin
      set_cfg(k, 4'h0, 3'b000, 4'd15, 0, 0);
      mlp[k] = 0; mbp[k] = 0; mhp[k] = 0; exp_audio[k] = 0;
      for (int j = 0; j < 4; j++) smp[k][j] = 0;
    end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(slot_o == 0, "R1", "reset slot", int'(slot_o), 0);
    chk(audio_o == '0, "R1", "reset audio", int'(audio_o[15:0]), 0);
    chk(valid_o == '0, "R1", "reset valid", int'(valid_o), 0);
    rst_ni = 1'b1;

    // R3 direct sum saturates high, then low
    cur_tag = "R3"; smode = 1;
    frames(2);
    chk(exp_audio[0] == 30719, "R3", "saturated positive level", exp_audio[0], 30719);
    smode = 2;
    frames(2);
    chk(exp_audio[1] == -30720, "R3", "saturated negative level", exp_audio[1], -30720);

    // R8 zero volume
    cur_tag = "R8"; smode = 0;
    for (int k = 0; k < NC; k++) set_cfg(k, 4'h0, 3'b000, 4'd0, 0, 0);
    frames(2);
    chk(exp_audio[0] == 0, "R8", "zero volume", exp_audio[0], 0);

    // R2 routing only, filter taps off
    cur_tag = "R2"; smode = 3;
    for (int k = 0; k < NC; k++) set_cfg(k, 4'($urandom), 3'b000, 4'd15, 8000, 16000);
    frames(4);
    for (int k = 0; k < NC; k++) set_cfg(k, 4'b1010, 3'b000, 4'd15, 8000, 16000);
    frames(2);

    // R4 / R5 / R6 one tap at a time
    cur_tag = "R4";
    for (int k = 0; k < NC; k++) set_cfg(k, 4'hF, 3'b001, 4'd15, int'($urandom_range(16383)), int'($urandom_range(32767)));
    frames(6);
    cur_tag = "R5";
    for (int k = 0; k < NC; k++) md[k] = 3'b010;
    frames(6);
    cur_tag = "R6";
    for (int k = 0; k < NC; k++) md[k] = 3'b100;
    frames(6);

    // R7 mixed modes and routes
    cur_tag = "R7";
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < NC; k++) rand_cfg(k);
      frames(2);
    end

    // R9 chips independent
    cur_tag = "R9"; smode = 0;
    set_cfg(0, 4'h7, 3'b111, 4'd12, 12000, 20000);
    set_cfg(1, 4'h0, 3'b000, 4'd0, 0, 0);
    frames(3);
    chk(exp_audio[1] == 0, "R9", "silent second chip", exp_audio[1], 0);
    set_cfg(0, 4'h0, 3'b000, 4'd0, 0, 0);
    set_cfg(1, 4'hF, 3'b011, 4'd9, 3000, 30000);
    frames(3);

    // long random run, full-range samples
    cur_tag = "R3 R4 R5 R6 R7";
    for (int i = 0; i < 15; i++) begin
      smode = (i % 5 == 4) ? 3 : 0;
      for (int k = 0; k < NC; k++) rand_cfg(k);
      frames(2);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule